// File: doc/BRIEF.md
# Oversampled Mid-Bit Clock Recovery

This block recovers a one-cycle data-valid strobe from a serial line that may carry noise and edge jitter. It divides every bit period into sixteen phase slots. A slot tick comes from a divider on the system clock, and the divider ratio follows a two-bit rate code that is captured while reset is held. A phase counter advances one slot per tick. The strobe fires when the counter reaches the middle slot. At the same clock the block captures the synchronized line level and holds it on `dout` until the next strobe.

The phase does not snap to each edge. A transition seen on a slot tick moves the counter by at most one slot, so the strobe drifts toward the averaged bit center and single jittered edges are filtered. A start pulse from an upstream preamble detector disarms the strobe. The first line edge after that pulse presets the phase so that the first strobe lands half a bit later. From then on the loop trains on the alternating preamble and keeps tracking through the payload. Nothing detects the end of data, so the strobe runs on until the next start pulse.

Top module: `clk_recover`

## Requirements
- R1: While reset is held, and after it is released, `strobe` and `dout` are 0, and no strobe appears before a start pulse has been followed by a line edge, whatever the line does.
- R2: The rate code is captured while reset is asserted. Changing `rate_sel` after reset is released has no effect on timing.
- R3: A slot tick occurs every `BASE_DIV >> rate` clock cycles. Rate code 0 is the slowest and code 3 the fastest. A bit spans 16 slots, and with edges aligned the strobe repeats every 16 slots.
- R4: Once `start` has fallen, the first slot tick that sees the synchronized line differ from its value at the previous tick presets the phase. The first strobe then comes 8 slot ticks after that tick. Edges seen while `start` is high do not preset the phase, and no strobe appears before the preset.
- R5: `strobe` is high for exactly one clock cycle. From the cycle after `start` is seen high, strobes stop until a new preset per R4.
- R6: `rx_in` passes through a two-flop synchronizer. On the clock edge that ends a strobe cycle, `dout` takes the synchronized level. Between strobes it holds.
- R7: The phase slot is counted from the tracked bit boundary, which is slot 0, and the strobe is at slot 8. An edge seen on a tick in slots 1 to 7 delays all following strobes by one slot. An edge seen in slots 8 to 15 advances them by one slot. An edge in slot 0 changes nothing.
- R8: A single edge displaced by several slots from the tracked boundary shifts the following strobes by only one slot, not by the full displacement.
- R9: With no line edges after training, strobes keep coming every 16 slot ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the rate code is captured while it is high |
| rx_in | input | 1 | Serial line, asynchronous to clk |
| rate_sel | input | 2 | Rate code, 0 = slowest and 3 = fastest |
| start | input | 1 | Start-of-data pulse from the preamble detector, synchronous to clk |
| strobe | output | 1 | One-cycle data-valid pulse near the bit center |
| dout | output | 1 | Line level captured at the last strobe |

## Verification
The bench aims at the edges of the loop's correction rule. It sends one edge a slot late, one a slot early and one three slots late. A design that hard-resynchronizes would move the strobe by three slots on the last one, and a design with the correction sign swapped would move it the wrong way. An edge sent while `start` is still high checks that the preset waits for the fall of `start`; a design that trained on that edge would strobe eight ticks too early. Each rate code is run with `rate_sel` changed after reset. A divider that does not latch the code, or that shifts the wrong way, puts every strobe on the wrong cycle. A stop pulse followed by a quiet line checks that the strobe is gated off and does not restart on its own.

// File: rtl/clk_recover.sv
module clk_recover #(
  parameter int BASE_DIV = 208,
  parameter int PHASES   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_in,
  input  logic [1:0] rate_sel,
  input  logic       start,
  output logic       strobe,
  output logic       dout
);
  localparam int DW   = $clog2(BASE_DIV + 1);
  localparam int PW   = $clog2(PHASES);
  localparam int HALF = PHASES / 2;

  logic [1:0]    rate_q;
  logic [DW-1:0] div_cnt, lim;
  logic [PW-1:0] ph;
  logic          rx_m, rx_s, rx_t;
  logic          waiting, armed;
  logic          tick, edge_seen, early, late, preset;

  assign lim       = DW'(BASE_DIV >> rate_q);
  assign tick      = (div_cnt == lim - 1'b1);
  assign edge_seen = tick && (rx_s != rx_t);
  assign early     = (ph != '0) && (ph < PW'(HALF));
  assign late      = (ph >= PW'(HALF));
  assign preset    = edge_seen && waiting && !start;
  assign strobe    = tick && armed && (ph == PW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= rate_sel;
      div_cnt <= '0;
      rx_m    <= 1'b0;
      rx_s    <= 1'b0;
      rx_t    <= 1'b0;
      ph      <= '0;
      waiting <= 1'b0;
      armed   <= 1'b0;
      dout    <= 1'b0;
    end else begin
      rx_m    <= rx_in;
      rx_s    <= rx_m;
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        rx_t <= rx_s;
        if (preset)                 ph <= PW'(1);
        else if (edge_seen && early) ph <= ph;
        else if (edge_seen && late)  ph <= ph + PW'(2);
        else                         ph <= ph + 1'b1;
      end
      if (start) begin
        waiting <= 1'b1;
        armed   <= 1'b0;
      end else if (preset) begin
        waiting <= 1'b0;
        armed   <= 1'b1;
      end
      if (strobe) dout <= rx_s;
    end
  end

  p_rate_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(rate_q));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  p_quiet_after_start_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> !strobe);

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (dout == $past(rx_s)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(dout));

  p_no_strobe_unarmed_r4: assert property (@(posedge clk) disable iff (rst)
    (waiting && !edge_seen) |=> !strobe);
endmodule

// File: tb/clk_recover_tb.sv
module clk_recover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx = 1'b0;
  logic [1:0] rate_sel = 2'd2;
  logic       start = 1'b0;
  logic       strobe, dout;

  int n = 0;
  int lim = 8;
  int checks = 0;
  int fails = 0;
  int strobe_cnt = 0;
  bit done = 1'b0;

  int    q_cyc[$];
  bit    q_d[$];
  string q_req[$];

  bit    chk_d = 1'b0;
  bit    exp_valid = 1'b0;
  bit    exp_d = 1'b0;
  string exp_req = "";
  bit    last_d = 1'b0;

  clk_recover #(.BASE_DIV(BASE), .PHASES(16)) u_dut (
    .clk(clk), .rst(rst), .rx_in(rx), .rate_sel(rate_sel),
    .start(start), .strobe(strobe), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) n <= rst ? 0 : n + 1;

  always @(negedge clk) if (!rst) begin
    if (chk_d) begin
      chk_d = 1'b0;
      if (exp_valid) begin
        checks++;
        if (dout !== exp_d) begin
          fails++;
          $display("FAIL %s data: actual %0b expected %0b", exp_req, dout, exp_d);
        end
      end
      last_d = dout;
    end
    if (strobe === 1'b1) begin
      strobe_cnt++;
      checks++;
      if (dout !== last_d) begin
        fails++;
        $display("FAIL R6 hold before strobe: actual %0b expected %0b", dout, last_d);
      end
      checks++;
      if (q_cyc.size() == 0) begin
        fails++;
        exp_valid = 1'b0;
        $display("FAIL R5 unexpected strobe: actual cycle %0d expected none", n);
      end else begin
        exp_valid = 1'b1;
        exp_d   = q_d.pop_front();
        exp_req = q_req.pop_front();
        if (n != q_cyc[0])
          begin
            fails++;
            $display("FAIL %s strobe cycle: actual %0d expected %0d", exp_req, n, q_cyc[0]);
          end
        void'(q_cyc.pop_front());
      end
      chk_d = 1'b1;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] r);
    rst = 1'b1;
    rate_sel = r;
    lim = BASE >> r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    last_d = 1'b0;
    chk_d = 1'b0;
  endtask

  task automatic at_tick(input int k);
    while (n < (k - 1) * lim) @(negedge clk);
  endtask

  task automatic drive_rx(input int k, input logic v);
    at_tick(k);
    rx = v;
  endtask

  task automatic set_start(input int k, input logic v);
    at_tick(k);
    start = v;
  endtask

  task automatic expect_strobe(input int k, input bit d, input string req);
    q_cyc.push_back(k * lim - 1);
    q_d.push_back(d);
    q_req.push_back(req);
  endtask

  task automatic drain(input string req);
    check(q_cyc.size() == 0, {req, " missing strobes"}, q_cyc.size(), 0);
    q_cyc.delete(); q_d.delete(); q_req.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int base_cnt;
    do_reset(2'd2);
    // R1: reset state, no strobes without a start pulse
    check(strobe === 1'b0, "R1 strobe after reset", strobe, 0);
    check(dout === 1'b0, "R1 dout after reset", dout, 0);
    drive_rx(3, 1'b1);
    drive_rx(5, 1'b0);
    drive_rx(20, 1'b1);
    at_tick(40);
    check(strobe_cnt == 0, "R1 strobes before start", strobe_cnt, 0);

    // R4: edge during start high is ignored, training on the next edge
    set_start(41, 1'b1);
    drive_rx(42, 1'b0);
    set_start(45, 1'b0);
    at_tick(50);
    check(strobe_cnt == 0, "R4 strobes before preset edge", strobe_cnt, 0);
    base_cnt = strobe_cnt;
    expect_strobe(58, 1'b1, "R4");
    expect_strobe(74, 1'b0, "R3");
    expect_strobe(90, 1'b1, "R3");
    expect_strobe(106, 1'b0, "R6");
    expect_strobe(122, 1'b1, "R6");
    expect_strobe(139, 1'b0, "R7 late");
    expect_strobe(154, 1'b1, "R7 early");
    expect_strobe(171, 1'b0, "R8");
    expect_strobe(187, 1'b0, "R9");
    expect_strobe(203, 1'b0, "R9");
    drive_rx(50, 1'b1);
    drive_rx(66, 1'b0);
    drive_rx(82, 1'b1);
    drive_rx(98, 1'b0);
    drive_rx(114, 1'b1);
    drive_rx(131, 1'b0);
    drive_rx(146, 1'b1);
    drive_rx(165, 1'b0);
    // R5: start stops the free-running strobe
    set_start(210, 1'b1);
    set_start(212, 1'b0);
    at_tick(245);
    check(strobe_cnt - base_cnt == 10, "R5 strobe count after stop", strobe_cnt - base_cnt, 10);
    drain("R9");

    // R2 and R3: every rate code, with rate_sel changed after reset
    for (int r = 0; r < 4; r++) begin
      rx = 1'b0;
      do_reset(2'(r));
      rate_sel = 2'(r) ^ 2'd2;
      base_cnt = strobe_cnt;
      set_start(2, 1'b1);
      set_start(4, 1'b0);
      expect_strobe(14, 1'b1, "R3 R2");
      expect_strobe(30, 1'b1, "R3 R2");
      expect_strobe(46, 1'b1, "R3 R2");
      drive_rx(6, 1'b1);
      set_start(50, 1'b1);
      set_start(51, 1'b0);
      at_tick(70);
      check(strobe_cnt - base_cnt == 3, "R2 strobe count per rate", strobe_cnt - base_cnt, 3);
      drain("R3");
    end
    summary();
  end
endmodule